// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block runs the entry sequence of an 8-bit processor core when an interrupt is accepted. Three request inputs (non-maskable, fast and normal) are caught in pending latches. When the core raises `boundary_i` between instructions, the sequencer picks the highest-priority request that is not masked and takes a snapshot of the core's registers. It then writes the required bytes to the system stack, one byte per cycle, through a memory write port. After that it reads the two-byte handler vector and returns the new program counter, condition code byte, stack pointer and cycle cost to the core.

The fast request stacks only the program counter and the condition codes, and marks the stacked frame as partial. The non-maskable and normal requests stack the whole register file and mark the frame as complete. The kinds also differ in which mask bits they raise, which vector they read and how many cycles they cost.

The controller is a single state machine with six states:
- `ST_IDLE` waits for a boundary with an eligible request. The transition *accept* leads to `ST_PUSH`.
- `ST_PUSH` writes one stack byte per cycle. It stays in this state until the condition-code slot has been written; the transition *last byte* leads to `ST_VEC_HI`.
- `ST_VEC_HI` issues the read of the vector high byte and always moves on to `ST_VEC_LO`.
- `ST_VEC_LO` issues the read of the low byte and captures the high byte, then always moves on to `ST_VEC_FIN`.
- `ST_VEC_FIN` captures the low byte and forms the results, then always moves on to `ST_DONE`.
- `ST_DONE` pulses the completion handshake and the transition *complete* returns to `ST_IDLE`.

Top module: `intr_entry_seq`

## Requirements
- R1: Priority among pending and eligible requests is non-maskable, then fast, then normal. A boundary takes at most one request.
- R2: A fast request is not eligible while CC bit 6 (F) is 1. A normal request is not eligible while CC bit 4 (I) is 1. A masked request stays pending. A boundary with no eligible request causes no memory access, and `busy_o` stays low.
- R3: Every stack byte is written at the current stack pointer minus one, and the pointer is decremented before each write. `new_s_o` equals `s_i` minus the number of bytes pushed.
- R4: A fast entry writes 3 bytes: PC low, PC high, then CC. In the stacked CC, bit 7 (E) is cleared.
- R5: A non-maskable or normal entry writes 12 bytes in this order: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. In the stacked CC, bit 7 (E) is set.
- R6: `new_cc_o` is the stacked CC with bits 4 and 6 set for fast and non-maskable entries. For a normal entry only bit 4 is set, and bit 6 keeps its value.
- R7: The vector is read from 16'hFFF6 for fast, 16'hFFF8 for normal and 16'hFFFC for non-maskable entries. The read is big-endian: the high byte comes from the lower address, and the next address follows in the next cycle. Read data returns one cycle after the read strobe. `new_pc_o` is the assembled vector.
- R8: `cycles_o` reports 10 for a fast entry and 19 for a normal or non-maskable entry.
- R9: The pending latch of a request is cleared when that request is taken. Other pending requests stay and are taken at later boundaries.
- R10: After reset the block is idle, with `busy_o`, `done_o`, `mem_we_o` and `mem_re_o` all low. `busy_o` is high from the cycle after accept until `done_o`. `done_o` is a one-cycle pulse, and the result outputs are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| nmi_req_i | input | 1 | Non-maskable request (latched) |
| fast_req_i | input | 1 | Fast request (latched) |
| norm_req_i | input | 1 | Normal request (latched) |
| pc_i | input | 16 | Program counter to stack |
| u_i | input | 16 | User stack pointer to stack |
| y_i | input | 16 | Y index to stack |
| x_i | input | 16 | X index to stack |
| s_i | input | 16 | System stack pointer before entry |
| dp_i | input | 8 | Direct page register to stack |
| b_i | input | 8 | Accumulator B to stack |
| a_i | input | 8 | Accumulator A to stack |
| cc_i | input | 8 | Condition codes (E=7, F=6, I=4) |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_re_o | output | 1 | Vector byte read strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Stack byte being written |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle completion handshake |
| new_pc_o | output | 16 | Handler address |
| new_cc_o | output | 8 | Condition codes after entry |
| new_s_o | output | 16 | Stack pointer after pushes |
| cycles_o | output | 6 | Cycle cost of the entry |

## Verification
The bench builds the block with its default vectors, cycle costs and a 6-bit cost field, so all three request kinds are in play.

It sweeps all eight request combinations against all four settings of the F and I mask bits. The stacked E bit is varied between cases. After the first entry, the bench raises further boundaries with both masks cleared. This makes the priority order, the masking and the pending-clear behaviour observable one entry at a time, until the pending latches are empty.

Each stack byte, address and vector read is compared with values that the bench works out from the snapshot register values.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_NMI,
        KIND_FAST,
        KIND_NORM
    } irq_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_VEC_FIN,
        ST_DONE
    } seq_state_e;

    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_I = 4;

    localparam int SLOT_W   = 4;
    localparam int SLOT_CNT = 12;
    localparam logic [SLOT_W-1:0] SLOT_PCL = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_PCH = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_CC  = 4'(SLOT_CNT - 1);

    typedef struct packed {
        logic [15:0] pc;
        logic [15:0] u;
        logic [15:0] y;
        logic [15:0] x;
        logic [7:0]  dp;
        logic [7:0]  b;
        logic [7:0]  a;
        logic [7:0]  cc;
    } cpu_snap_t;

endpackage

// File: rtl/intr_entry_arb.sv
module intr_entry_arb
    import intr_entry_pkg::*;
(
    input  logic [2:0] pend_i,
    input  logic [7:0] cc_i,
    output irq_kind_e  kind_o
);
    logic fast_ok;
    logic norm_ok;

    assign fast_ok = pend_i[1] && !cc_i[CC_F];
    assign norm_ok = pend_i[2] && !cc_i[CC_I];

    always_comb begin
        if (pend_i[0])
            kind_o = KIND_NMI;
        else if (fast_ok)
            kind_o = KIND_FAST;
        else if (norm_ok)
            kind_o = KIND_NORM;
        else
            kind_o = KIND_NONE;
    end
endmodule

// File: rtl/intr_entry_bytesel.sv
module intr_entry_bytesel
    import intr_entry_pkg::*;
(
    input  cpu_snap_t         snap_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [7:0]        byte_o
);
    always_comb begin
        unique case (slot_i)
            4'd0:    byte_o = snap_i.pc[7:0];
            4'd1:    byte_o = snap_i.pc[15:8];
            4'd2:    byte_o = snap_i.u[7:0];
            4'd3:    byte_o = snap_i.u[15:8];
            4'd4:    byte_o = snap_i.y[7:0];
            4'd5:    byte_o = snap_i.y[15:8];
            4'd6:    byte_o = snap_i.x[7:0];
            4'd7:    byte_o = snap_i.x[15:8];
            4'd8:    byte_o = snap_i.dp;
            4'd9:    byte_o = snap_i.b;
            4'd10:   byte_o = snap_i.a;
            default: byte_o = snap_i.cc;
        endcase
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter logic [15:0] NMI_VEC   = 16'hFFFC,
    parameter logic [15:0] FAST_VEC  = 16'hFFF6,
    parameter logic [15:0] NORM_VEC  = 16'hFFF8,
    parameter int          CYC_W     = 6,
    parameter int          NMI_COST  = 19,
    parameter int          FAST_COST = 10,
    parameter int          NORM_COST = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              nmi_req_i,
    input  logic              fast_req_i,
    input  logic              norm_req_i,
    input  logic [15:0]       pc_i,
    input  logic [15:0]       u_i,
    input  logic [15:0]       y_i,
    input  logic [15:0]       x_i,
    input  logic [15:0]       s_i,
    input  logic [7:0]        dp_i,
    input  logic [7:0]        b_i,
    input  logic [7:0]        a_i,
    input  logic [7:0]        cc_i,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [15:0]       mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       new_pc_o,
    output logic [7:0]        new_cc_o,
    output logic [15:0]       new_s_o,
    output logic [CYC_W-1:0]  cycles_o
);
    seq_state_e        state_q, state_d;
    irq_kind_e         kind_sel, kind_q;
    logic [2:0]        pend_q, take_vec;
    logic              accept;
    cpu_snap_t         snap_q;
    logic [15:0]       s_q;
    logic [SLOT_W-1:0] slot_q, slot_next;
    logic              last_slot;
    logic [7:0]        push_byte;
    logic [7:0]        vec_hi_q;
    logic [15:0]       vec_addr;
    logic [7:0]        cc_entry;
    logic [7:0]        cc_masks;
    logic [CYC_W-1:0]  cost;
    logic [15:0]       new_pc_q;
    logic [7:0]        new_cc_q;
    logic [CYC_W-1:0]  cyc_q;

    intr_entry_arb arb_i (
        .pend_i (pend_q),
        .cc_i   (cc_i),
        .kind_o (kind_sel)
    );

    intr_entry_bytesel sel_i (
        .snap_i (snap_q),
        .slot_i (slot_q),
        .byte_o (push_byte)
    );

    assign accept = (state_q == ST_IDLE) && boundary_i && (kind_sel != KIND_NONE);

    always_comb begin
        take_vec = 3'b000;
        if (accept) begin
            unique case (kind_sel)
                KIND_NMI:  take_vec = 3'b001;
                KIND_FAST: take_vec = 3'b010;
                KIND_NORM: take_vec = 3'b100;
                default:   take_vec = 3'b000;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 3'b000;
        else
            pend_q <= (pend_q & ~take_vec) | {norm_req_i, fast_req_i, nmi_req_i};
    end

    // Entry value of CC: E marks whether the frame is the full register set.
    always_comb begin
        cc_entry = cc_i;
        cc_entry[CC_E] = (kind_sel != KIND_FAST);
    end

    // Fast entries jump from the PC high slot straight to the CC slot.
    assign last_slot = (slot_q == SLOT_CC);
    assign slot_next = (kind_q == KIND_FAST && slot_q == SLOT_PCH) ? SLOT_CC : slot_q + 4'd1;

    always_comb begin
        unique case (kind_q)
            KIND_FAST: begin
                vec_addr = FAST_VEC;
                cc_masks = 8'((1 << CC_I) | (1 << CC_F));
                cost     = CYC_W'(FAST_COST);
            end
            KIND_NORM: begin
                vec_addr = NORM_VEC;
                cc_masks = 8'(1 << CC_I);
                cost     = CYC_W'(NORM_COST);
            end
            default: begin
                vec_addr = NMI_VEC;
                cc_masks = 8'((1 << CC_I) | (1 << CC_F));
                cost     = CYC_W'(NMI_COST);
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_PUSH;
            ST_PUSH:    if (last_slot) state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_VEC_FIN;
            ST_VEC_FIN: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= KIND_NONE;
            snap_q   <= '0;
            s_q      <= '0;
            slot_q   <= SLOT_PCL;
            vec_hi_q <= '0;
            new_pc_q <= '0;
            new_cc_q <= '0;
            cyc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        kind_q    <= kind_sel;
                        snap_q.pc <= pc_i;
                        snap_q.u  <= u_i;
                        snap_q.y  <= y_i;
                        snap_q.x  <= x_i;
                        snap_q.dp <= dp_i;
                        snap_q.b  <= b_i;
                        snap_q.a  <= a_i;
                        snap_q.cc <= cc_entry;
                        s_q       <= s_i;
                        slot_q    <= SLOT_PCL;
                    end
                end
                ST_PUSH: begin
                    s_q    <= s_q - 16'd1;
                    slot_q <= slot_next;
                end
                ST_VEC_LO: vec_hi_q <= mem_rdata_i;
                ST_VEC_FIN: begin
                    new_pc_q <= {vec_hi_q, mem_rdata_i};
                    new_cc_q <= snap_q.cc | cc_masks;
                    cyc_q    <= cost;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_PUSH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = s_q - 16'd1;
                mem_wdata_o = push_byte;
            end
            ST_VEC_HI: begin
                mem_re_o   = 1'b1;
                mem_addr_o = vec_addr;
            end
            ST_VEC_LO: begin
                mem_re_o   = 1'b1;
                mem_addr_o = vec_addr + 16'd1;
            end
            default: ;
        endcase
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
    assign new_pc_o = new_pc_q;
    assign new_cc_o = new_cc_q;
    assign new_s_o  = s_q;
    assign cycles_o = cyc_q;

endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic [15:0] mem_addr_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [7:0]  new_cc_o
);
    // R3: consecutive stack writes walk downward one byte at a time
    p_stack_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 16'd1));

    // R7: a vector read is two consecutive reads at ascending addresses
    p_vec_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && !$past(mem_re_o)) |=> (mem_re_o && mem_addr_o == $past(mem_addr_o) + 16'd1));

    // R7: the port never reads and writes in the same cycle
    p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R6: every entry leaves the normal mask raised
    p_i_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> new_cc_o[4]);

    // R10: the handshake lasts one cycle and comes while busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
endmodule

bind intr_entry_seq intr_entry_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .new_cc_o   (new_cc_o)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        nmi_req_i = 1'b0, fast_req_i = 1'b0, norm_req_i = 1'b0;
    logic [15:0] pc_i = '0, u_i = '0, y_i = '0, x_i = '0, s_i = '0;
    logic [7:0]  dp_i = '0, b_i = '0, a_i = '0, cc_i = '0;
    logic        mem_we_o, mem_re_o, busy_o, done_o;
    logic [15:0] mem_addr_o, new_pc_o, new_s_o;
    logic [7:0]  mem_wdata_o, new_cc_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [5:0]  cycles_o;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;

    intr_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .nmi_req_i(nmi_req_i), .fast_req_i(fast_req_i), .norm_req_i(norm_req_i),
        .pc_i(pc_i), .u_i(u_i), .y_i(y_i), .x_i(x_i), .s_i(s_i),
        .dp_i(dp_i), .b_i(b_i), .a_i(a_i), .cc_i(cc_i),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .new_pc_o(new_pc_o),
        .new_cc_o(new_cc_o), .new_s_o(new_s_o), .cycles_o(cycles_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] vbyte(logic [15:0] a);
        return a[7:0] ^ 8'h3C ^ {a[3:0], 4'h0};
    endfunction

    // Memory model: read data one cycle after the strobe
    always @(posedge clk) if (mem_re_o) mem_rdata_i <= vbyte(mem_addr_o);

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 nmi, 2 fast, 3 normal
    function automatic int pick(logic [2:0] pend, logic [7:0] cc);
        if (pend[0]) return 1;
        if (pend[1] && !cc[6]) return 2;
        if (pend[2] && !cc[4]) return 3;
        return 0;
    endfunction

    function automatic logic [7:0] slot_byte(int s, logic [7:0] ccs);
        case (s)
            0: return pc_i[7:0];   1: return pc_i[15:8];
            2: return u_i[7:0];    3: return u_i[15:8];
            4: return y_i[7:0];    5: return y_i[15:8];
            6: return x_i[7:0];    7: return x_i[15:8];
            8: return dp_i;        9: return b_i;
            10: return a_i;        default: return ccs;
        endcase
    endfunction

    task automatic run_entry(input int kind);
        logic [15:0] wa [0:15];
        logic [7:0]  wd [0:15];
        logic [15:0] ra [0:3];
        int nw = 0;
        int nr = 0;
        int nbytes;
        logic [7:0]  ccs;
        logic [7:0]  cco;
        logic [15:0] vec;
        int cost;
        bit got_done = 0;
        @(negedge clk) boundary_i = 1'b1;
        @(negedge clk) boundary_i = 1'b0;
        if (kind == 0) begin
            for (int k = 0; k < 4; k++) begin
                chk(!mem_we_o && !mem_re_o && !busy_o, "R2", "idle after boundary with nothing eligible",
                    {mem_we_o, mem_re_o, busy_o}, 0);
                @(negedge clk);
            end
            return;
        end
        chk(busy_o, "R10", "busy after accept", busy_o, 1);
        for (int k = 0; k < 40; k++) begin
            if (mem_we_o && nw < 16) begin wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; nw++; end
            if (mem_re_o && nr < 4) begin ra[nr] = mem_addr_o; nr++; end
            if (done_o) begin got_done = 1; break; end
            @(negedge clk);
        end
        chk(got_done, "R10", "done reached", got_done, 1);
        ccs = cc_i;
        ccs[7] = (kind != 2);
        nbytes = (kind == 2) ? 3 : 12;
        chk(nw == nbytes, (kind == 2) ? "R4" : "R5", "stack byte count", nw, nbytes);
        for (int k = 0; k < nbytes && k < nw; k++) begin
            int sl;
            sl = (kind == 2 && k == 2) ? 11 : k;
            chk(wa[k] == s_i - 16'(k + 1), "R3", "stack address", wa[k], s_i - 16'(k + 1));
            chk(wd[k] == slot_byte(sl, ccs), (kind == 2) ? "R4" : "R5", "stack byte",
                wd[k], slot_byte(sl, ccs));
        end
        vec  = (kind == 1) ? 16'hFFFC : (kind == 2) ? 16'hFFF6 : 16'hFFF8;
        cost = (kind == 2) ? 10 : 19;
        cco  = ccs | ((kind == 3) ? 8'h10 : 8'h50);
        chk(nr == 2 && ra[0] == vec, "R7", "vector read address", ra[0], vec);
        chk(new_pc_o == {vbyte(vec), vbyte(vec + 16'd1)}, "R7", "new pc",
            new_pc_o, {vbyte(vec), vbyte(vec + 16'd1)});
        chk(new_cc_o == cco, "R6", "new cc", new_cc_o, cco);
        chk(new_s_o == s_i - 16'(nbytes), "R3", "new s", new_s_o, s_i - 16'(nbytes));
        chk(32'(cycles_o) == cost, "R8", "cycle cost", cycles_o, cost);
        @(negedge clk);
        chk(!done_o && !busy_o, "R10", "done is one cycle", {done_o, busy_o}, 0);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 8; r++) begin
                logic [2:0] pend;
                logic [7:0] cc_base;
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R10", "reset state",
                    {busy_o, done_o, mem_we_o, mem_re_o}, 0);
                pc_i = 16'h1234 + 16'(r * 257) + 16'(m * 16);
                u_i  = 16'hA0B1 ^ 16'(r << 4);
                y_i  = 16'hC2D3 + 16'(m);
                x_i  = 16'hE4F5 - 16'(r);
                s_i  = 16'h7F00 + 16'(m * 64 + r);
                dp_i = 8'h11 + 8'(r);
                b_i  = 8'h22 + 8'(m);
                a_i  = 8'h33 ^ 8'(r * 3);
                cc_base = {r[0], m[1], 1'b0, m[0], 4'(r + m)};
                pend = 3'(r);
                @(negedge clk);
                {norm_req_i, fast_req_i, nmi_req_i} = 3'(r);
                @(negedge clk);
                {norm_req_i, fast_req_i, nmi_req_i} = 3'b000;
                for (int round = 0; round < 4; round++) begin
                    int kind;
                    cc_i = (round == 0) ? cc_base : (cc_base & 8'hAF);
                    kind = pick(pend, cc_i);
                    // R1 / R9: exactly the highest eligible request is served, then cleared
                    run_entry(kind);
                    if (kind == 0) break;
                    pend[kind - 1] = 1'b0;
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule